// File: doc/BRIEF.md
# Operand Effective Address Generator

This block produces the 14-bit operand or jump-target address for a small 8-bit processor core. For each instruction, the decoder presents the addressing-mode class, the instruction class and the low five opcode bits. The fetch stream then supplies any operand bytes, one per `byte_valid_i` strobe. The block returns the resolved address with a one-cycle `addr_valid_o` strobe. If the mode does not fit the instruction class, it returns a one-cycle `illegal_o` strobe instead.

There are three encoded modes: short, direct and extended. Indexed access is not a separate mode. A data window sits at direct-page location $00E. A short or direct access that resolves to that location is redirected to the direct-page address held in the index register. The register value enters on `x_value_i`. A write to the index register that completes in the same cycle arrives on `x_wr_en_i`/`x_wr_data_i`, and that new value is the one used.

A four-state machine controls the sequence. **IDLE** accepts requests. A direct request goes **IDLE → DIR_BYTE**, and **DIR_BYTE → IDLE** on its operand byte. An extended request goes **IDLE → EXT_HIGH**, then **EXT_HIGH → EXT_LOW** on the first byte, then **EXT_LOW → IDLE** on the second byte. Short, illegal and reserved requests leave the machine in **IDLE**. Every non-IDLE state holds while `byte_valid_i` is low.

Top module: `opaddr_gen`

## Requirements
- R1: A synchronous reset returns the machine to IDLE. In the cycle after the reset edge, `addr_valid_o` and `illegal_o` are both low.
- R2: Mode code 0 (short) with instruction class 0, 1 or 2 (clear, load, store) asserts `addr_valid_o` in the cycle after the request, with `addr_o` = {9'b0, opfield_i}.
- R3: Mode code 0 with any instruction class from 3 to 7 asserts `illegal_o` for one cycle after the request and does not assert `addr_valid_o`.
- R4: Mode code 1 (direct) waits any number of cycles for one operand byte. `addr_valid_o` rises the cycle after that byte with `addr_o` = {6'b0, byte}.
- R5: Mode code 2 (extended) with class 3 (jump) or 4 (call) takes two operand bytes. `addr_o` = {first[5:0], second}, valid the cycle after the second byte, and bits 7:6 of the first byte are ignored.
- R6: Mode code 2 with any class other than 3 or 4 asserts `illegal_o` the cycle after the request and consumes no bytes.
- R7: A short or direct address equal to 14'h00E is replaced by {6'b0, X}. Every other short or direct address passes unchanged.
- R8: The X value used for R7 is taken in the cycle in which the address is captured. That is the request cycle for short mode and the byte cycle for direct mode. When `x_wr_en_i` is high in that cycle, `x_wr_data_i` is used in place of `x_value_i`.
- R9: While the machine is in DIR_BYTE, EXT_HIGH or EXT_LOW, `req_valid_i` is ignored. The assembly in progress completes with its own address.
- R10: Mode code 3 is reserved and always asserts `illegal_o` the cycle after the request.
- R11: `addr_valid_o` and `illegal_o` are never high together. An operand byte that arrives while the machine is in IDLE produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | New instruction request (sampled in IDLE only) |
| mode_i | input | 2 | Addressing mode: 0 short, 1 direct, 2 extended, 3 reserved |
| class_i | input | 3 | Instruction class: 0 clear, 1 load, 2 store, 3 jump, 4 call, 5-7 other |
| opfield_i | input | 5 | Low opcode bits holding the short address |
| byte_valid_i | input | 1 | Operand byte strobe from the fetch stream |
| byte_data_i | input | 8 | Operand byte |
| x_value_i | input | 8 | Current index register contents |
| x_wr_en_i | input | 1 | Index register write completing this cycle |
| x_wr_data_i | input | 8 | Value being written to the index register |
| addr_o | output | 14 | Resolved effective address |
| addr_valid_o | output | 1 | One-cycle strobe: `addr_o` holds a new address |
| illegal_o | output | 1 | One-cycle strobe: illegal mode and class pairing |

## Verification
Short requests are driven with every legal class and with illegal ones, so that a fault in the legality decode is separated from a fault in zero-extension. Direct and extended requests are driven both with back-to-back operand bytes and with idle gaps between them, which exposes states that fail to hold. Stray requests are also sent mid-assembly, which exposes a state machine that restarts when it should not. Window remapping is tried on $00E and on its neighbour $00F, with and without a simultaneous index write. This distinguishes a missing remap, an over-broad address compare and a stale index value. A behavioural model in the bench predicts valid, illegal and address on every clock.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    typedef enum logic [1:0] {
        AM_SHORT    = 2'd0,
        AM_DIRECT   = 2'd1,
        AM_EXTENDED = 2'd2,
        AM_RSVD     = 2'd3
    } amode_t;

    typedef enum logic [2:0] {
        IC_CLEAR = 3'd0,
        IC_LOAD  = 3'd1,
        IC_STORE = 3'd2,
        IC_JUMP  = 3'd3,
        IC_CALL  = 3'd4,
        IC_ALU_A = 3'd5,
        IC_ALU_B = 3'd6,
        IC_OTHER = 3'd7
    } iclass_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DIR_BYTE = 2'd1,
        ST_EXT_HIGH = 2'd2,
        ST_EXT_LOW  = 2'd3
    } gen_state_t;

endpackage

// File: rtl/opaddr_legal.sv
module opaddr_legal
    import opaddr_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic [2:0] class_i,
    output logic       illegal_o
);

    amode_t  mode;
    iclass_t cls;
    logic    short_class_ok;
    logic    ext_class_ok;

    assign mode = amode_t'(mode_i);
    assign cls  = iclass_t'(class_i);

    always_comb begin
        short_class_ok = 1'b0;
        ext_class_ok   = 1'b0;
        unique case (cls)
            IC_CLEAR, IC_LOAD, IC_STORE: short_class_ok = 1'b1;
            IC_JUMP, IC_CALL:            ext_class_ok   = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        unique case (mode)
            AM_SHORT:    illegal_o = !short_class_ok;
            AM_DIRECT:   illegal_o = 1'b0;
            AM_EXTENDED: illegal_o = !ext_class_ok;
            AM_RSVD:     illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/opaddr_remap.sv
module opaddr_remap #(
    parameter int ADDR_W    = 14,
    parameter int BYTE_W    = 8,
    parameter int WIN_ADDR  = 14,
    parameter bit WINDOW_EN = 1'b1
) (
    input  logic [ADDR_W-1:0] raw_addr_i,
    input  logic [BYTE_W-1:0] x_value_i,
    input  logic              x_wr_en_i,
    input  logic [BYTE_W-1:0] x_wr_data_i,
    output logic [ADDR_W-1:0] eff_addr_o
);

    localparam int PAD_W = ADDR_W - BYTE_W;

    generate
        if (WINDOW_EN) begin : g_window
            logic [BYTE_W-1:0] x_eff;
            logic              hit;

            assign x_eff = x_wr_en_i ? x_wr_data_i : x_value_i;
            assign hit   = (raw_addr_i == ADDR_W'(WIN_ADDR));
            assign eff_addr_o = hit ? {{PAD_W{1'b0}}, x_eff} : raw_addr_i;
        end else begin : g_passthru
            logic unused_x;
            assign unused_x   = ^{x_value_i, x_wr_en_i, x_wr_data_i};
            assign eff_addr_o = raw_addr_i;
        end
    endgenerate

endmodule

// File: rtl/opaddr_fsm.sv
module opaddr_fsm
    import opaddr_pkg::*;
#(
    parameter int ADDR_W  = 14,
    parameter int BYTE_W  = 8,
    parameter int SHORT_W = 5
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_valid_i,
    input  logic [1:0]         mode_i,
    input  logic [2:0]         class_i,
    input  logic [SHORT_W-1:0] opfield_i,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_data_i,
    input  logic               illegal_req_i,
    input  logic [ADDR_W-1:0]  eff_addr_i,
    output logic [ADDR_W-1:0]  cand_addr_o,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               addr_valid_o,
    output logic               illegal_o
);

    localparam int HI_W    = ADDR_W - BYTE_W;
    localparam int SPAD_W  = ADDR_W - SHORT_W;

    gen_state_t      state_q, state_d;
    logic [HI_W-1:0] hi_q;
    logic            take_short, take_dir, take_ext, raise_ill;

    // next-state and event decode
    always_comb begin
        state_d    = state_q;
        take_short = 1'b0;
        take_dir   = 1'b0;
        take_ext   = 1'b0;
        raise_ill  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (illegal_req_i) begin
                        raise_ill = 1'b1;
                    end else begin
                        unique case (amode_t'(mode_i))
                            AM_SHORT:    take_short = 1'b1;
                            AM_DIRECT:   state_d    = ST_DIR_BYTE;
                            AM_EXTENDED: state_d    = ST_EXT_HIGH;
                            AM_RSVD:     raise_ill  = 1'b1;
                        endcase
                    end
                end
            end
            ST_DIR_BYTE: begin
                if (byte_valid_i) begin
                    take_dir = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
            ST_EXT_HIGH: begin
                if (byte_valid_i) state_d = ST_EXT_LOW;
            end
            ST_EXT_LOW: begin
                if (byte_valid_i) begin
                    take_ext = 1'b1;
                    state_d  = ST_IDLE;
                end
            end
        endcase
    end

    // candidate address presented to the window remap
    assign cand_addr_o = (state_q == ST_IDLE) ? {{SPAD_W{1'b0}}, opfield_i}
                                              : {{HI_W{1'b0}}, byte_data_i};

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    // high address byte capture
    always_ff @(posedge clk_i) begin
        if (rst_i)                                      hi_q <= '0;
        else if (state_q == ST_EXT_HIGH && byte_valid_i) hi_q <= byte_data_i[HI_W-1:0];
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            addr_o       <= '0;
            addr_valid_o <= 1'b0;
            illegal_o    <= 1'b0;
        end else begin
            addr_valid_o <= take_short | take_dir | take_ext;
            illegal_o    <= raise_ill;
            if (take_short || take_dir) addr_o <= eff_addr_i;
            else if (take_ext)          addr_o <= {hi_q, byte_data_i};
        end
    end

    // checks
    p_reset_r1: assert property (@(posedge clk_i)
        rst_i |=> (!addr_valid_o && !illegal_o));

    p_short_valid_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && req_valid_i && mode_i == AM_SHORT && class_i <= IC_STORE)
        |=> (addr_valid_o && addr_o[ADDR_W-1:BYTE_W] == '0));

    p_short_illegal_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && req_valid_i && mode_i == AM_SHORT && class_i > IC_STORE)
        |=> (illegal_o && !addr_valid_o));

    p_direct_page_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_DIR_BYTE && byte_valid_i)
        |=> (addr_valid_o && addr_o[ADDR_W-1:BYTE_W] == '0));

    p_ext_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_EXT_LOW && byte_valid_i)
        |=> (addr_valid_o && addr_o[BYTE_W-1:0] == $past(byte_data_i)));

    p_ext_illegal_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && req_valid_i && mode_i == AM_EXTENDED
         && class_i != IC_JUMP && class_i != IC_CALL)
        |=> (illegal_o && state_q == ST_IDLE));

    p_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != ST_IDLE && !byte_valid_i) |=> $stable(state_q));

    p_reserved_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && req_valid_i && mode_i == AM_RSVD) |=> illegal_o);

    p_exclusive_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !(addr_valid_o && illegal_o));

    p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && !req_valid_i) |=> (!addr_valid_o && !illegal_o));

endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
    import opaddr_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int BYTE_W   = 8,
    parameter int SHORT_W  = 5,
    parameter int WIN_ADDR = 14
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_valid_i,
    input  logic [1:0]         mode_i,
    input  logic [2:0]         class_i,
    input  logic [SHORT_W-1:0] opfield_i,
    input  logic               byte_valid_i,
    input  logic [BYTE_W-1:0]  byte_data_i,
    input  logic [BYTE_W-1:0]  x_value_i,
    input  logic               x_wr_en_i,
    input  logic [BYTE_W-1:0]  x_wr_data_i,
    output logic [ADDR_W-1:0]  addr_o,
    output logic               addr_valid_o,
    output logic               illegal_o
);

    logic              illegal_req;
    logic [ADDR_W-1:0] cand_addr;
    logic [ADDR_W-1:0] eff_addr;

    opaddr_legal u_legal (
        .mode_i    (mode_i),
        .class_i   (class_i),
        .illegal_o (illegal_req)
    );

    opaddr_remap #(
        .ADDR_W    (ADDR_W),
        .BYTE_W    (BYTE_W),
        .WIN_ADDR  (WIN_ADDR),
        .WINDOW_EN (1'b1)
    ) u_remap (
        .raw_addr_i  (cand_addr),
        .x_value_i   (x_value_i),
        .x_wr_en_i   (x_wr_en_i),
        .x_wr_data_i (x_wr_data_i),
        .eff_addr_o  (eff_addr)
    );

    opaddr_fsm #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .SHORT_W (SHORT_W)
    ) u_fsm (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .req_valid_i   (req_valid_i),
        .mode_i        (mode_i),
        .class_i       (class_i),
        .opfield_i     (opfield_i),
        .byte_valid_i  (byte_valid_i),
        .byte_data_i   (byte_data_i),
        .illegal_req_i (illegal_req),
        .eff_addr_i    (eff_addr),
        .cand_addr_o   (cand_addr),
        .addr_o        (addr_o),
        .addr_valid_o  (addr_valid_o),
        .illegal_o     (illegal_o)
    );

endmodule

// File: tb/test_opaddr_gen.sv
`timescale 1ns/1ps
module test_opaddr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic [2:0]  cls = 3'd0;
    logic [4:0]  opf = 5'd0;
    logic        bv = 1'b0;
    logic [7:0]  bd = 8'd0;
    logic [7:0]  xv = 8'd0;
    logic        xw = 1'b0;
    logic [7:0]  xd = 8'd0;
    logic [13:0] addr;
    logic        avalid, ill;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int mst = 0;
    int hi_b = 0;
    int ev = 0, ei = 0, ea = 0;

    always #5 clk = ~clk;

    opaddr_gen i_opaddr_gen (
        .clk_i(clk), .rst_i(rst), .req_valid_i(req), .mode_i(mode),
        .class_i(cls), .opfield_i(opf), .byte_valid_i(bv), .byte_data_i(bd),
        .x_value_i(xv), .x_wr_en_i(xw), .x_wr_data_i(xd),
        .addr_o(addr), .addr_valid_o(avalid), .illegal_o(ill)
    );

    function automatic int window(input int a);
        if (a == 14) return xw ? int'(xd) : int'(xv);
        return a;
    endfunction

    always @(posedge clk) begin
        ev = 0;
        ei = 0;
        if (rst) begin
            mst = 0;
        end else if (mst == 0) begin
            if (req) begin
                if (mode == 0) begin
                    if (cls <= 2) begin ev = 1; ea = window(int'(opf)); end
                    else ei = 1;
                end else if (mode == 1) mst = 1;
                else if (mode == 2) begin
                    if (cls == 3 || cls == 4) mst = 2; else ei = 1;
                end else ei = 1;
            end
        end else if (bv) begin
            if (mst == 1) begin ev = 1; ea = window(int'(bd)); mst = 0; end
            else if (mst == 2) begin hi_b = int'(bd) % 64; mst = 3; end
            else begin ev = 1; ea = hi_b * 256 + int'(bd); mst = 0; end
        end
    end

    task automatic step(input string tag);
        @(posedge clk);
        #1;
        checks++;
        if (int'(avalid) != ev || int'(ill) != ei || (ev != 0 && int'(addr) != ea)) begin
            fails++;
            $display("FAIL %s: valid=%0d ill=%0d addr=%h expected valid=%0d ill=%0d addr=%h",
                     tag, avalid, ill, addr, ev, ei, ea[13:0]);
        end
        req = 1'b0; bv = 1'b0; xw = 1'b0;
    endtask

    task automatic ask(input logic [1:0] m, input logic [2:0] c, input logic [4:0] o, input string tag);
        req = 1'b1; mode = m; cls = c; opf = o;
        step(tag);
    endtask

    task automatic feed(input logic [7:0] b, input string tag);
        bv = 1'b1; bd = b;
        step(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        step("R1"); step("R1");
        rst = 1'b0;
        step("R1");
        // short, legal classes
        ask(2'd0, 3'd0, 5'h13, "R2"); step("R2");
        ask(2'd0, 3'd1, 5'h1F, "R2");
        ask(2'd0, 3'd2, 5'h00, "R2"); step("R2");
        // short, illegal classes
        ask(2'd0, 3'd3, 5'h04, "R3"); step("R3");
        ask(2'd0, 3'd6, 5'h04, "R3"); step("R3");
        // direct with and without gap
        ask(2'd1, 3'd5, 5'h00, "R4"); step("R4"); step("R4");
        feed(8'hA5, "R4"); step("R4");
        ask(2'd1, 3'd1, 5'h00, "R4"); feed(8'hFF, "R4"); step("R4");
        // extended
        ask(2'd2, 3'd4, 5'h00, "R5"); feed(8'hFF, "R5"); feed(8'h34, "R5"); step("R5");
        ask(2'd2, 3'd3, 5'h00, "R5"); step("R5"); feed(8'h12, "R5");
        step("R5"); feed(8'h00, "R5"); step("R5");
        ask(2'd2, 3'd1, 5'h00, "R6"); feed(8'h55, "R6"); step("R6");
        // window remap
        xv = 8'h77;
        ask(2'd0, 3'd1, 5'h0E, "R7"); step("R7");
        ask(2'd0, 3'd1, 5'h0F, "R7"); step("R7");
        xv = 8'hC3;
        ask(2'd1, 3'd2, 5'h00, "R7"); feed(8'h0E, "R7"); step("R7");
        ask(2'd1, 3'd2, 5'h00, "R7"); feed(8'h0D, "R7"); step("R7");
        ask(2'd2, 3'd3, 5'h00, "R7"); feed(8'h00, "R7"); feed(8'h0E, "R7"); step("R7");
        // forwarding of a simultaneous index write
        xv = 8'h11; xw = 1'b1; xd = 8'h5A;
        ask(2'd0, 3'd0, 5'h0E, "R8"); step("R8");
        ask(2'd1, 3'd0, 5'h00, "R8");
        xw = 1'b1; xd = 8'hE2; feed(8'h0E, "R8"); step("R8");
        xw = 1'b1; xd = 8'h99; ask(2'd0, 3'd1, 5'h03, "R8"); step("R8");
        // requests ignored mid-assembly
        ask(2'd2, 3'd4, 5'h00, "R9"); ask(2'd0, 3'd0, 5'h07, "R9");
        feed(8'h3C, "R9"); ask(2'd3, 3'd0, 5'h00, "R9");
        feed(8'h81, "R9"); step("R9");
        ask(2'd1, 3'd0, 5'h00, "R9"); ask(2'd2, 3'd3, 5'h00, "R9");
        feed(8'h42, "R9"); step("R9");
        // reserved mode
        ask(2'd3, 3'd3, 5'h00, "R10"); step("R10");
        ask(2'd3, 3'd0, 5'h0E, "R10"); step("R10");
        // stray byte in idle, then back-to-back shorts
        feed(8'h77, "R11"); feed(8'h0E, "R11"); step("R11");
        ask(2'd0, 3'd0, 5'h01, "R11"); ask(2'd0, 3'd3, 5'h02, "R11");
        ask(2'd0, 3'd2, 5'h03, "R11"); step("R11");
        // mid-run reset
        ask(2'd2, 3'd3, 5'h00, "R1"); feed(8'h01, "R1");
        rst = 1'b1; step("R1");
        rst = 1'b0; feed(8'h02, "R1"); step("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule